// File: doc/BRIEF.md
# Serial Memory Command Front-End (SPI Slave)

This block is the serial-side controller of a small byte-wide memory that only ever acts as an SPI slave. While the active-low select is asserted it samples the data input on rising clock edges and shifts bits in MSB first. The first byte is taken as a command. Memory commands are followed by a two-byte address field, and then by a stream of data bytes. The block turns these commands into read-port addressing, one-cycle write strobes and status-register updates for an array that sits beside it. On falling serial-clock edges it shifts read data out on a serial output with a separate output-enable.

All pins are assumed to be synchronised to the system clock `clk`. The block runs several system clocks per serial half-period and finds serial-clock edges by comparing successive samples. The state machine has these states: `S_OPC` (take the command byte), `S_ADDR_HI` / `S_ADDR_LO` (take the address field), `S_RD_DATA` (stream array data out), `S_WR_DATA` (take bytes to write), `S_ST_RD` (stream the status byte), `S_ST_WR` (take a new status byte), `S_SKIP` (take and discard bytes after a finished command) and `S_DEAD` (unknown command: deaf until deselect).

The transitions are as follows. Any state goes to `S_OPC` while `cs_n` is high. When a byte completes in `S_OPC`: codes 0x06 and 0x04 go to `S_SKIP`, 0x05 goes to `S_ST_RD`, 0x01 goes to `S_ST_WR`, 0x03 and 0x02 go to `S_ADDR_HI`, and any other code goes to `S_DEAD`. When a byte completes, `S_ADDR_HI` goes to `S_ADDR_LO`, and `S_ADDR_LO` goes to `S_RD_DATA` or `S_WR_DATA` depending on the command. `S_ST_WR` goes to `S_SKIP` after one byte. The other states hold until deselect.

Top module: `spi_mem_fe`

## Requirements
- R1: While `cs_n` is high, `so_oe` is 0, SI is ignored, and the next selection starts again with a command byte. After reset `so_oe` and `mem_we` are 0.
- R2: SI is sampled on SCK rising edges and SO changes on SCK falling edges. Both are MSB first. The first byte after selection is the command.
- R3: Command 0x03 followed by a 16-bit address field reads the array from the address formed by the field's low ADDR_W bits. Successive bytes come from incrementing addresses, and the address wraps from 2^ADDR_W-1 to 0.
- R4: Command 0x02 followed by an address pulses `mem_we` for exactly one clock per completed data byte, with that byte and an incrementing address. This happens only if the write-enable latch was 1 and `wr_busy` was 0 when the command byte completed.
- R5: Command 0x06 sets the write-enable latch and 0x04 clears it. The latch also clears on the deselect that ends a frame in which a write or status write took effect.
- R6: Command 0x05 streams the status byte repeatedly: bits 7:2 hold the stored status field, bit 1 the write-enable latch and bit 0 `wr_busy`.
- R7: Command 0x01 stores bits 7:2 of the next byte as the status field, under the same gating as R4. Without the gate the field is unchanged.
- R8: After an unknown command byte the block drives no output, issues no write and accepts no SI until `cs_n` rises. The following frame works normally.
- R9: Hold starts when `hold_n` is low while SCK is low and ends when `hold_n` is high while SCK is low. During hold, SCK edges and SI are ignored and `so_oe` is 0, and the transfer resumes at the bit where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| sck | input | 1 | Serial clock (slave input only) |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause request |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (0 = high impedance) |
| wr_busy | input | 1 | Array write cycle in progress |
| mem_rd_addr | output | ADDR_W | Array read address |
| mem_rd_data | input | 8 | Array read data (combinational) |
| mem_we | output | 1 | Array write strobe |
| mem_wr_addr | output | ADDR_W | Array write address |
| mem_wr_data | output | 8 | Array write data |

## Verification
A serial-clock edge takes effect one system clock after it is sampled. SO therefore settles one clock after a falling edge, and `mem_we` pulses one clock after the rising edge that completes a byte. Hold entry and exit also land one clock after `hold_n` is seen with SCK low. The bench keeps every SCK level for four system clocks and samples SO and `so_oe` at the end of each low phase, just before the next rising edge, so each result has had three spare clocks to settle. Writes and status changes are checked only after the frame has ended.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CMD_WEN  = 8'h06;
    localparam logic [BYTE_W-1:0] CMD_WDIS = 8'h04;
    localparam logic [BYTE_W-1:0] CMD_RSTA = 8'h05;
    localparam logic [BYTE_W-1:0] CMD_WSTA = 8'h01;
    localparam logic [BYTE_W-1:0] CMD_READ = 8'h03;
    localparam logic [BYTE_W-1:0] CMD_WRIT = 8'h02;

    typedef enum logic [3:0] {
        S_OPC, S_ADDR_HI, S_ADDR_LO, S_RD_DATA, S_WR_DATA,
        S_ST_RD, S_ST_WR, S_SKIP, S_DEAD
    } fe_state_t;
endpackage

// File: rtl/spi_pin_sense.sv
module spi_pin_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic held,
    output logic cs_rise
);
    logic sck_d, cs_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
            held  <= 1'b0;
        end else begin
            sck_d <= sck;
            cs_d  <= cs_n;
            if (cs_n)
                held <= 1'b0;
            else if (!sck)
                held <= !hold_n;
        end
    end

    assign sck_rise = sck && !sck_d && !cs_n && !held;
    assign sck_fall = !sck && sck_d && !cs_n && !held;
    assign cs_rise  = cs_n && !cs_d;
endmodule

// File: rtl/spi_rx_byte.sv
module spi_rx_byte #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         si,
    output logic         byte_done,
    output logic [W-1:0] byte_val,
    output logic         at_bit0
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt;
    logic [W-1:0]  sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            sr  <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (shift_en) begin
            sr  <= {sr[W-2:0], si};
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign byte_done = shift_en && (cnt == LAST);
    assign byte_val  = {sr[W-2:0], si};
    assign at_bit0   = (cnt == '0);
endmodule

// File: rtl/spi_tx_byte.sv
module spi_tx_byte #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         fall_en,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic         sout,
    output logic         valid
);
    logic [W-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr    <= '0;
            valid <= 1'b0;
        end else if (clr) begin
            sr    <= '0;
            valid <= 1'b0;
        end else if (fall_en) begin
            if (load) begin
                sr    <= din;
                valid <= 1'b1;
            end else begin
                sr <= {sr[W-2:0], 1'b0};
            end
        end
    end

    assign sout = sr[W-1];
endmodule

// File: rtl/spi_mem_fe.sv
module spi_mem_fe
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              hold_n,
    output logic              so,
    output logic              so_oe,
    input  logic              wr_busy,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [BYTE_W-1:0] mem_rd_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [BYTE_W-1:0] mem_wr_data
);
    localparam int HI_W = ADDR_W - BYTE_W;
    localparam int ST_W = BYTE_W - 2;

    fe_state_t state_q, state_d;

    logic sck_rise, sck_fall, held, cs_rise;
    logic byte_done, at_bit0;
    logic [BYTE_W-1:0] rx_byte;
    logic [HI_W-1:0]   addr_hi;
    logic [ADDR_W-1:0] addr;
    logic [ST_W-1:0]   stat_field;
    logic wel, cmd_rd, gate_ok, wrote;
    logic tx_state, tx_valid;
    logic [BYTE_W-1:0] tx_din;

    spi_pin_sense u_pins (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .held(held), .cs_rise(cs_rise)
    );

    spi_rx_byte #(.W(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .clr(cs_n),
        .shift_en(sck_rise && (state_q != S_DEAD)), .si(si),
        .byte_done(byte_done), .byte_val(rx_byte), .at_bit0(at_bit0)
    );

    assign tx_state = (state_q == S_RD_DATA) || (state_q == S_ST_RD);
    assign tx_din   = (state_q == S_ST_RD) ? {stat_field, wel, wr_busy} : mem_rd_data;

    spi_tx_byte #(.W(BYTE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .clr(cs_n),
        .fall_en(sck_fall && tx_state), .load(at_bit0), .din(tx_din),
        .sout(so), .valid(tx_valid)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cs_n) begin
            state_d = S_OPC;
        end else if (byte_done) begin
            unique case (state_q)
                S_OPC: begin
                    case (rx_byte)
                        CMD_WEN, CMD_WDIS:  state_d = S_SKIP;
                        CMD_RSTA:           state_d = S_ST_RD;
                        CMD_WSTA:           state_d = S_ST_WR;
                        CMD_READ, CMD_WRIT: state_d = S_ADDR_HI;
                        default:            state_d = S_DEAD;
                    endcase
                end
                S_ADDR_HI: state_d = S_ADDR_LO;
                S_ADDR_LO: state_d = cmd_rd ? S_RD_DATA : S_WR_DATA;
                S_ST_WR:   state_d = S_SKIP;
                S_RD_DATA, S_WR_DATA, S_ST_RD, S_SKIP, S_DEAD: state_d = state_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OPC;
        else        state_q <= state_d;
    end

    // outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_hi     <= '0;
            addr        <= '0;
            stat_field  <= '0;
            wel         <= 1'b0;
            cmd_rd      <= 1'b0;
            gate_ok     <= 1'b0;
            wrote       <= 1'b0;
            mem_we      <= 1'b0;
            mem_wr_addr <= '0;
            mem_wr_data <= '0;
        end else begin
            mem_we <= 1'b0;
            if (cs_rise && wrote) begin
                wel   <= 1'b0;
                wrote <= 1'b0;
            end
            if (!cs_n && byte_done) begin
                unique case (state_q)
                    S_OPC: begin
                        if (rx_byte == CMD_WEN)  wel <= 1'b1;
                        if (rx_byte == CMD_WDIS) wel <= 1'b0;
                        cmd_rd  <= (rx_byte == CMD_READ);
                        gate_ok <= wel && !wr_busy;
                    end
                    S_ADDR_HI: addr_hi <= rx_byte[HI_W-1:0];
                    S_ADDR_LO: addr    <= {addr_hi, rx_byte};
                    S_RD_DATA: addr    <= addr + 1'b1;
                    S_WR_DATA: begin
                        if (gate_ok) begin
                            mem_we      <= 1'b1;
                            mem_wr_addr <= addr;
                            mem_wr_data <= rx_byte;
                            wrote       <= 1'b1;
                        end
                        addr <= addr + 1'b1;
                    end
                    S_ST_WR: begin
                        if (gate_ok) begin
                            stat_field <= rx_byte[BYTE_W-1:2];
                            wrote      <= 1'b1;
                        end
                    end
                    S_ST_RD, S_SKIP, S_DEAD: ;
                endcase
            end
        end
    end

    assign so_oe       = !cs_n && !held && tx_state && tx_valid;
    assign mem_rd_addr = addr;
endmodule

// File: rtl/spi_mem_fe_chk.sv
module spi_mem_fe_chk
    import spi_mem_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cs_n,
    input logic      sck,
    input logic      so_oe,
    input logic      mem_we,
    input fe_state_t state_q,
    input logic      held
);
    AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !so_oe);                                             // R1
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);                                          // R4
    AST_WE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(state_q) == S_WR_DATA);                      // R4
    AST_DEAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DEAD && !cs_n) |=> (state_q == S_DEAD));        // R8
    AST_HOLD_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cs_n) && (held != $past(held))) |-> !$past(sck));     // R9
endmodule

bind spi_mem_fe spi_mem_fe_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .so_oe(so_oe),
    .mem_we(mem_we), .state_q(state_q), .held(held)
);

// File: tb/tb_spi_mem_fe.sv
module tb_spi_mem_fe;
    localparam int AW   = 10;
    localparam int HALF = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wr_busy = 1'b0;
    logic so, so_oe, mem_we;
    logic [AW-1:0] mem_rd_addr, mem_wr_addr;
    logic [7:0] mem_rd_data, mem_wr_data;
    logic [7:0] mem [DEPTH];
    int checks = 0, fails = 0, we_count = 0, cyc = 0;

    always #2.5 clk = ~clk;

    spi_mem_fe #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .so(so), .so_oe(so_oe), .wr_busy(wr_busy), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .mem_we(mem_we), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data)
    );

    assign mem_rd_data = mem[mem_rd_addr];
    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_wr_addr] <= mem_wr_data;
            we_count <= we_count + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bit(input logic b, output logic s, output logic oe);
        si = b;
        tick(HALF);
        s  = so;
        oe = so_oe;
        sck = 1'b1;
        tick(HALF);
        sck = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                        output logic oe_all, output logic oe_any);
        logic s, oe;
        oe_all = 1'b1;
        oe_any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            spi_bit(tx[i], s, oe);
            rx[i] = s;
            oe_all &= oe;
            oe_any |= oe;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic desel();
        tick(HALF);
        cs_n = 1'b1;
        tick(HALF);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r; logic a, b;
        sel(); xfer(op, r, a, b); desel();
    endtask

    task automatic rdsr(output logic [7:0] v);
        logic [7:0] r; logic a, b;
        sel(); xfer(8'h05, r, a, b); xfer(8'h00, v, a, b); desel();
    endtask

    task automatic t_reset();
        chk(so_oe == 1'b0, "R1 reset so_oe", so_oe, 0);
        chk(mem_we == 1'b0, "R1 reset mem_we", mem_we, 0);
    endtask

    task automatic t_status();
        logic [7:0] v;
        rdsr(v);
        chk(v == 8'h00, "R6 status after reset", v, 8'h00);
        cmd1(8'h06);
        rdsr(v);
        chk(v == 8'h02, "R5 R6 wel set", v, 8'h02);
        wr_busy = 1'b1;
        rdsr(v);
        chk(v == 8'h03, "R6 busy bit", v, 8'h03);
        wr_busy = 1'b0;
        cmd1(8'h04);
        rdsr(v);
        chk(v == 8'h00, "R5 wel cleared by 0x04", v, 8'h00);
    endtask

    task automatic t_write();
        logic [7:0] r, v; logic a, b;
        int n0;
        cmd1(8'h06);
        sel(); xfer(8'h02, r, a, b); xfer(8'hF8, r, a, b); xfer(8'h05, r, a, b);
        xfer(8'hA5, r, a, b); xfer(8'h5A, r, a, b); desel();
        chk(mem[5] == 8'hA5, "R4 write byte0", mem[5], 8'hA5);
        chk(mem[6] == 8'h5A, "R4 write byte1 incr", mem[6], 8'h5A);
        rdsr(v);
        chk(v == 8'h00, "R5 wel cleared after write", v, 8'h00);
        n0 = we_count;
        sel(); xfer(8'h02, r, a, b); xfer(8'h00, r, a, b); xfer(8'h07, r, a, b);
        xfer(8'h11, r, a, b); desel();
        chk(we_count == n0, "R4 no write without wel", we_count, n0);
        chk(mem[7] == 8'((7*37+11)), "R4 mem unchanged", mem[7], 8'((7*37+11)));
        cmd1(8'h06);
        wr_busy = 1'b1;
        sel(); xfer(8'h02, r, a, b); xfer(8'h00, r, a, b); xfer(8'h07, r, a, b);
        xfer(8'h22, r, a, b); desel();
        wr_busy = 1'b0;
        chk(we_count == n0, "R4 no write while busy", we_count, n0);
        cmd1(8'h04);
    endtask

    task automatic t_read();
        logic [7:0] r, cmd; logic a, b;
        sel(); xfer(8'h03, cmd, a, b);
        chk(b == 1'b0, "R2 no output during command", b, 0);
        xfer(8'hFC, r, a, b); xfer(8'h03, r, a, b);
        for (int k = 0; k < 3; k++) begin
            xfer(8'h00, r, a, b);
            chk(r == mem[3+k], "R3 R2 read stream", r, mem[3+k]);
            chk(a == 1'b1, "R3 so_oe during read", a, 1);
        end
        desel();
        chk(so_oe == 1'b0, "R1 hi-z after deselect", so_oe, 0);
        sel(); xfer(8'h03, r, a, b); xfer(8'h03, r, a, b); xfer(8'hFF, r, a, b);
        xfer(8'h00, r, a, b);
        chk(r == mem[DEPTH-1], "R3 read top", r, mem[DEPTH-1]);
        xfer(8'h00, r, a, b);
        chk(r == mem[0], "R3 wrap to 0", r, mem[0]);
        desel();
    endtask

    task automatic t_wrsr();
        logic [7:0] r, v; logic a, b;
        cmd1(8'h06);
        sel(); xfer(8'h01, r, a, b); xfer(8'hF3, r, a, b); desel();
        rdsr(v);
        chk(v == 8'hF0, "R7 status field stored", v, 8'hF0);
        sel(); xfer(8'h01, r, a, b); xfer(8'h0C, r, a, b); desel();
        rdsr(v);
        chk(v == 8'hF0, "R7 status write gated", v, 8'hF0);
    endtask

    task automatic t_invalid();
        logic [7:0] r, v; logic a, b, any;
        int n0;
        n0 = we_count;
        any = 1'b0;
        cmd1(8'h06);
        sel(); xfer(8'hFF, r, a, b);
        xfer(8'h03, r, a, b); any |= b;
        xfer(8'h00, r, a, b); any |= b;
        xfer(8'h02, r, a, b); any |= b;
        xfer(8'h00, r, a, b); any |= b;
        desel();
        chk(any == 1'b0, "R8 silent after invalid", any, 0);
        chk(we_count == n0, "R8 no write after invalid", we_count, n0);
        rdsr(v);
        chk(v == 8'hF2, "R8 next frame normal", v, 8'hF2);
        cmd1(8'h04);
    endtask

    task automatic t_hold();
        logic [7:0] r, got; logic a, b, s, oe;
        sel(); xfer(8'h03, r, a, b); xfer(8'h00, r, a, b);
        // pause in middle of address low byte
        for (int i = 7; i >= 4; i--) spi_bit(1'(8'h10 >> i), s, oe);
        tick(2); hold_n = 1'b0; tick(HALF);
        for (int k = 0; k < 3; k++) begin
            si = ~si; sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
        end
        hold_n = 1'b1; tick(2);
        for (int i = 3; i >= 0; i--) spi_bit(1'(8'h10 >> i), s, oe);
        // pause in middle of data byte
        for (int i = 7; i >= 5; i--) begin spi_bit(1'b0, s, oe); got[i] = s; end
        tick(2); hold_n = 1'b0; tick(HALF);
        chk(so_oe == 1'b0, "R9 so_oe low in hold", so_oe, 0);
        for (int k = 0; k < 4; k++) begin
            sck = 1'b1; tick(HALF);
            chk(so_oe == 1'b0, "R9 sck ignored in hold", so_oe, 0);
            sck = 1'b0; tick(HALF);
        end
        hold_n = 1'b1; tick(2);
        for (int i = 4; i >= 0; i--) begin spi_bit(1'b0, s, oe); got[i] = s; end
        chk(got == mem[16], "R9 data resumes after hold", got, mem[16]);
        // hold request while sck high waits for sck low
        si = 1'b0; tick(HALF); got[7] = so; sck = 1'b1; tick(2);
        hold_n = 1'b0; tick(2);
        chk(so_oe == 1'b1, "R9 no hold while sck high", so_oe, 1);
        sck = 1'b0; tick(HALF);
        chk(so_oe == 1'b0, "R9 hold once sck low", so_oe, 0);
        hold_n = 1'b1; tick(2);
        for (int i = 6; i >= 0; i--) begin spi_bit(1'b0, s, oe); got[i] = s; end
        chk(got == mem[17], "R9 byte intact across hold", got, mem[17]);
        desel();
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'(i*37+11);
        tick(3);
        rst_n = 1'b1;
        tick(3);
        t_reset();
        t_status();
        t_write();
        t_read();
        t_wrsr();
        t_invalid();
        t_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule